// File: doc/BRIEF.md
# Single-Cycle Subset RISC Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It fetches from an internal instruction array at the program counter. It decodes the 6-bit opcode into datapath controls and reads two operands from a 32-entry register file. It computes in an ALU, optionally reads or writes an internal data array, writes a result back, and selects the next program counter. All of this happens within the same cycle. The instruction subset is three-operand arithmetic and logic (add, subtract, and, or, nor, signed set-less-than), word load, word store, branch-if-equal and an unconditional jump.

Both memories are filled through a single load port before the core runs. The core is normally held in reset while they are filled. Every architectural effect of the current instruction is driven on observation outputs: the write-back bus, the store bus, the ALU flags and the fetched word. A surrounding system or a bench can follow execution on those outputs without reaching inside the core. The decoder first maps the opcode to an instruction class and then derives all controls from that class. ALU selection uses two levels: a 2-bit ALU operation from the class, refined by the funct field only for register operations.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active high. A clock edge with `rst` high sets the PC to 0. While `rst` is high, `reg_we_o` and `mem_we_o` are low, so the register file and data array are not modified.
- R2: Any instruction other than a taken branch or a jump moves the PC to PC+4 at the next clock edge.
- R3: Opcode 000000 selects a register operation with fields op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. The result is written to rd. The funct codes are add 100000, subtract 100010, and 100100, or 100101 and nor 100111.
- R4: Funct 101010 compares rs and rt as signed values and writes 1 to rd if rs is less, otherwise 0.
- R5: Opcode 100010 (load word) writes rt with the data word at byte address rs + sign-extended imm[15:0]. The data array is indexed by address bits [N:2].
- R6: Opcode 101011 (store word) writes rt to the data word at rs + sign-extended imm[15:0] at the clock edge. It drives `mem_we_o` high with that address and data and does not write any register.
- R7: Opcode 000100 (branch-if-equal) compares rs and rt by subtraction. If they are equal, the next PC is PC+4 + (sign-extended imm << 2), otherwise PC+4. It writes no register and no memory.
- R8: Opcode 000010 (jump) sets the next PC to {PC[31:28], target[25:0], 2'b00} and writes nothing.
- R9: Register 0 always reads as zero. A write whose destination is register 0 is dropped, and `reg_we_o` stays low for it.
- R10: Any other opcode is a no-op. It writes no register, writes no memory, and advances the PC by 4.
- R11: `alu_zero_o` is high exactly when the ALU result is zero. `alu_ovf_o` flags signed overflow of an add (register add, load, store) or a subtract (register subtract, branch compare).
- R12: When `load_en` is high, `load_data` is written at the clock edge into the word selected by `load_addr[N:2]`. The target is the instruction array when `load_sel` is 0 and the data array when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Memory fill strobe |
| load_sel | input | 1 | Fill target: 0 instruction array, 1 data array |
| load_addr | input | 32 | Fill byte address |
| load_data | input | 32 | Fill word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word fetched at the PC |
| reg_we_o | output | 1 | Register write taking effect this cycle |
| reg_waddr_o | output | 5 | Register write destination |
| reg_wdata_o | output | 32 | Register write value |
| mem_we_o | output | 1 | Data store taking effect this cycle |
| mem_addr_o | output | 32 | Data byte address (ALU result) |
| mem_wdata_o | output | 32 | Store data (rt value) |
| alu_zero_o | output | 1 | ALU result is zero |
| alu_ovf_o | output | 1 | ALU signed overflow |

## Verification
The bound checker checks the following on every cycle:
- the PC returns to zero after reset;
- the PC advances by 4 for everything except branches and jumps, and jumps land on the concatenated target;
- stores, branches and unknown opcodes never write a register;
- a zero rs field always yields a zero operand.

Only the bench scenarios can show computed values. These include:
- the arithmetic results, the signed ordering of set-less-than, and overflow on a wrapping add;
- load data returned after a store to the same word;
- taken versus untaken branches, including a backward offset;
- a discarded write to register 0, observed later when that register is stored.

The bench's behavioural model confirms all of these cycle by cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN  = 32;
    localparam int RF_AW = 5;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100010;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        CLS_REG,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP,
        CLS_NOP
    } iclass_e;

    typedef enum logic [1:0] {
        AOP_ADDR  = 2'b00,
        AOP_CMP   = 2'b01,
        AOP_FUNCT = 2'b10,
        AOP_RSVD  = 2'b11
    } aluop_e;

    typedef enum logic [2:0] {
        FNSEL_ADD,
        FNSEL_SUB,
        FNSEL_AND,
        FNSEL_OR,
        FNSEL_NOR,
        FNSEL_SLT
    } alufn_e;

    typedef struct packed {
        logic   dst_is_rd;
        logic   opb_is_imm;
        logic   wb_from_mem;
        logic   reg_write;
        logic   mem_read;
        logic   mem_write;
        logic   branch;
        logic   jump;
        aluop_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output iclass_e    iclass,
    output ctrl_t      ctrl,
    output alufn_e     alufn
);

    always_comb begin
        unique case (opcode)
            OPC_REG:   iclass = CLS_REG;
            OPC_LOAD:  iclass = CLS_LOAD;
            OPC_STORE: iclass = CLS_STORE;
            OPC_BEQ:   iclass = CLS_BRANCH;
            OPC_JUMP:  iclass = CLS_JUMP;
            default:   iclass = CLS_NOP;
        endcase
    end

    always_comb begin
        ctrl = '{dst_is_rd: 1'b0, opb_is_imm: 1'b0, wb_from_mem: 1'b0,
                 reg_write: 1'b0, mem_read: 1'b0, mem_write: 1'b0,
                 branch: 1'b0, jump: 1'b0, alu_op: AOP_ADDR};
        unique case (iclass)
            CLS_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = AOP_FUNCT;
            end
            CLS_LOAD: begin
                ctrl.opb_is_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_write   = 1'b1;
                ctrl.mem_read    = 1'b1;
                ctrl.alu_op      = AOP_ADDR;
            end
            CLS_STORE: begin
                ctrl.opb_is_imm = 1'b1;
                ctrl.mem_write  = 1'b1;
                ctrl.alu_op     = AOP_ADDR;
            end
            CLS_BRANCH: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = AOP_CMP;
            end
            CLS_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_comb begin
        unique case (ctrl.alu_op)
            AOP_ADDR: alufn = FNSEL_ADD;
            AOP_CMP:  alufn = FNSEL_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_SUB:  alufn = FNSEL_SUB;
                    FN_AND:  alufn = FNSEL_AND;
                    FN_OR:   alufn = FNSEL_OR;
                    FN_NOR:  alufn = FNSEL_NOR;
                    FN_SLT:  alufn = FNSEL_SLT;
                    default: alufn = FNSEL_ADD;
                endcase
            end
            default: alufn = FNSEL_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alufn_e       fn,
    output logic [W-1:0] res,
    output logic         zero,
    output logic         ovf
);

    logic [W-1:0] sum;
    logic [W-1:0] diff;

    assign sum  = opa + opb;
    assign diff = opa - opb;

    always_comb begin
        ovf = 1'b0;
        unique case (fn)
            FNSEL_ADD: begin
                res = sum;
                ovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
            end
            FNSEL_SUB: begin
                res = diff;
                ovf = (opa[W-1] != opb[W-1]) && (diff[W-1] != opa[W-1]);
            end
            FNSEL_AND: res = opa & opb;
            FNSEL_OR:  res = opa | opb;
            FNSEL_NOR: res = ~(opa | opb);
            FNSEL_SLT: res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default:   res = sum;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/sc_pc.sv
module sc_pc
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take_branch,
    input  logic         take_jump,
    input  logic [W-1:0] br_offset,
    input  logic [25:0]  jtarget,
    output logic [W-1:0] pc,
    output logic [W-1:0] pc_seq
);

    logic [W-1:0] pc_next;
    logic [W-1:0] br_target;
    logic [W-1:0] j_target;

    assign pc_seq    = pc + W'(4);
    assign br_target = pc_seq + {br_offset[W-3:0], 2'b00};
    assign j_target  = {pc[W-1:W-4], jtarget, 2'b00};

    always_comb begin
        if (take_jump) begin
            pc_next = j_target;
        end else if (take_branch) begin
            pc_next = br_target;
        end else begin
            pc_next = pc_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_next;
        end
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic             load_sel,
    input  logic [XLEN-1:0]  load_addr,
    input  logic [XLEN-1:0]  load_data,
    output logic [XLEN-1:0]  pc_o,
    output logic [XLEN-1:0]  instr_o,
    output logic             reg_we_o,
    output logic [RF_AW-1:0] reg_waddr_o,
    output logic [XLEN-1:0]  reg_wdata_o,
    output logic             mem_we_o,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic [XLEN-1:0]  mem_wdata_o,
    output logic             alu_zero_o,
    output logic             alu_ovf_o
);

    localparam int IA = $clog2(IMEM_WORDS);
    localparam int DA = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0]  pc;
    logic [XLEN-1:0]  pc_seq;
    logic [XLEN-1:0]  instr;
    logic [5:0]       f_op;
    logic [RF_AW-1:0] f_rs;
    logic [RF_AW-1:0] f_rt;
    logic [RF_AW-1:0] f_rd;
    logic [5:0]       f_fn;
    logic [15:0]      f_imm;
    logic [25:0]      f_jt;

    iclass_e         iclass;
    ctrl_t           ctrl;
    alufn_e          alufn;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rs_data;
    logic [XLEN-1:0] rt_data;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic            alu_ovf;
    logic [XLEN-1:0] dm_rdata;
    logic [XLEN-1:0] wb_data;
    logic [RF_AW-1:0] wb_addr;
    logic            wb_en;
    logic            st_en;
    logic            br_taken;

    assign instr = imem[pc[IA+1:2]];
    assign f_op  = instr[31:26];
    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign f_fn  = instr[5:0];
    assign f_imm = instr[15:0];
    assign f_jt  = instr[25:0];

    sc_ctrl u_ctrl (
        .opcode (f_op),
        .funct  (f_fn),
        .iclass (iclass),
        .ctrl   (ctrl),
        .alufn  (alufn)
    );

    assign imm_ext = {{(XLEN-16){f_imm[15]}}, f_imm};

    sc_regfile #(.W(XLEN), .AW(RF_AW)) u_rf (
        .clk     (clk),
        .we      (wb_en),
        .waddr   (wb_addr),
        .wdata   (wb_data),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rs_data),
        .rdata_b (rt_data)
    );

    assign alu_b = ctrl.opb_is_imm ? imm_ext : rt_data;

    sc_alu #(.W(XLEN)) u_alu (
        .opa  (rs_data),
        .opb  (alu_b),
        .fn   (alufn),
        .res  (alu_y),
        .zero (alu_zero),
        .ovf  (alu_ovf)
    );

    assign dm_rdata = ctrl.mem_read ? dmem[alu_y[DA+1:2]] : '0;
    assign wb_data  = ctrl.wb_from_mem ? dm_rdata : alu_y;
    assign wb_addr  = ctrl.dst_is_rd ? f_rd : f_rt;
    assign wb_en    = ctrl.reg_write && (wb_addr != '0) && !rst;
    assign st_en    = ctrl.mem_write && !rst;
    assign br_taken = ctrl.branch && alu_zero;

    sc_pc #(.W(XLEN)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .take_branch (br_taken),
        .take_jump   (ctrl.jump),
        .br_offset   (imm_ext),
        .jtarget     (f_jt),
        .pc          (pc),
        .pc_seq      (pc_seq)
    );

    always_ff @(posedge clk) begin
        if (load_en && !load_sel) begin
            imem[load_addr[IA+1:2]] <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (load_en && load_sel) begin
            dmem[load_addr[DA+1:2]] <= load_data;
        end else if (st_en) begin
            dmem[alu_y[DA+1:2]] <= rt_data;
        end
    end

    assign pc_o        = pc;
    assign instr_o     = instr;
    assign reg_we_o    = wb_en;
    assign reg_waddr_o = wb_addr;
    assign reg_wdata_o = wb_data;
    assign mem_we_o    = st_en;
    assign mem_addr_o  = alu_y;
    assign mem_wdata_o = rt_data;
    assign alu_zero_o  = alu_zero;
    assign alu_ovf_o   = alu_ovf;

    logic unused_bits;
    assign unused_bits = ^{pc_seq, load_addr[XLEN-1:IA+2], load_addr[1:0],
                           instr[10:6], iclass};

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        reg_we,
    input logic        mem_we,
    input logic [31:0] rs_data
);

    logic known_op;
    assign known_op = (instr[31:26] == OPC_REG) || (instr[31:26] == OPC_LOAD) ||
                      (instr[31:26] == OPC_STORE) || (instr[31:26] == OPC_BEQ) ||
                      (instr[31:26] == OPC_JUMP);

    // R1
    rst_pc_zero_chk: assert property (@(posedge clk) rst |=> (pc == 32'd0));

    // R1
    rst_no_write_chk: assert property (@(posedge clk) rst |-> (!reg_we && !mem_we));

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        ((instr[31:26] != OPC_BEQ) && (instr[31:26] != OPC_JUMP))
        |=> (pc == $past(pc) + 32'd4));

    // R6
    store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_STORE) |-> !reg_we);

    // R7
    beq_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_BEQ) |-> (!reg_we && !mem_we));

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_JUMP)
        |=> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

    // R9
    r0_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_data == 32'd0));

    // R10
    unknown_op_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> (!reg_we && !mem_we));

endmodule

bind sc_core sc_core_chk u_sc_core_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc_o),
    .instr   (instr_o),
    .reg_we  (reg_we_o),
    .mem_we  (mem_we_o),
    .rs_data (rs_data)
);

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_sel = 1'b0;
    logic [31:0] load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o, instr_o, reg_wdata_o, mem_addr_o, mem_wdata_o;
    logic [4:0]  reg_waddr_o;
    logic        reg_we_o, mem_we_o, alu_zero_o, alu_ovf_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sc_core u_sc_core (
        .clk (clk), .rst (rst), .load_en (load_en), .load_sel (load_sel),
        .load_addr (load_addr), .load_data (load_data),
        .pc_o (pc_o), .instr_o (instr_o), .reg_we_o (reg_we_o),
        .reg_waddr_o (reg_waddr_o), .reg_wdata_o (reg_wdata_o),
        .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o),
        .mem_wdata_o (mem_wdata_o), .alu_zero_o (alu_zero_o),
        .alu_ovf_o (alu_ovf_o)
    );

    // behavioural reference state
    logic [31:0] prog [64];
    logic [31:0] mdm  [64];
    logic [31:0] mrf  [32];
    logic [31:0] mpc;
    int          plen;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int tgt);
        return {6'b000010, 26'(tgt)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at pc=%08h: actual=%08h expected=%08h", tag, mpc, act, exp);
        end
    endtask

    // compare current outputs with the model, then commit the model's state
    task automatic step();
        logic [31:0] ins, a, b, imm, res, nxt;
        logic        we, sw, alu_used, ovf;
        logic [4:0]  wa;
        string       tag;
        ins = prog[mpc[7:2]];
        a   = mrf[ins[25:21]];
        b   = mrf[ins[20:16]];
        imm = {{16{ins[15]}}, ins[15:0]};
        nxt = mpc + 4;
        we = 1'b0; sw = 1'b0; alu_used = 1'b1; ovf = 1'b0; wa = 5'd0; res = '0;
        tag = "R10";
        case (ins[31:26])
            6'b000000: begin
                wa = ins[15:11]; we = 1'b1; tag = "R3";
                case (ins[5:0])
                    6'b100010: begin res = a - b; ovf = (a[31] != b[31]) && (res[31] != a[31]); end
                    6'b100100: res = a & b;
                    6'b100101: res = a | b;
                    6'b100111: res = ~(a | b);
                    6'b101010: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
                    default:   begin res = a + b; ovf = (a[31] == b[31]) && (res[31] != a[31]); end
                endcase
            end
            6'b100010: begin
                res = a + imm; ovf = (a[31] == imm[31]) && (res[31] != a[31]);
                wa = ins[20:16]; we = 1'b1; tag = "R5";
            end
            6'b101011: begin
                res = a + imm; ovf = (a[31] == imm[31]) && (res[31] != a[31]);
                sw = 1'b1; tag = "R6";
            end
            6'b000100: begin
                res = a - b; ovf = (a[31] != b[31]) && (res[31] != a[31]); tag = "R7";
                if (a == b) nxt = mpc + 4 + (imm << 2);
            end
            6'b000010: begin
                alu_used = 1'b0; tag = "R8";
                nxt = {mpc[31:28], ins[25:0], 2'b00};
            end
            default: alu_used = 1'b0;
        endcase
        if (we && wa == 5'd0) tag = "R9";
        chk("R2", pc_o, mpc);
        chk("R12", instr_o, ins);
        chk(tag, {31'd0, reg_we_o}, {31'd0, we && (wa != 5'd0)});
        if (we && wa != 5'd0) begin
            chk(tag, {27'd0, reg_waddr_o}, {27'd0, wa});
            chk(tag, reg_wdata_o, (ins[31:26] == 6'b100010) ? mdm[res[7:2]] : res);
        end
        chk(tag, {31'd0, mem_we_o}, {31'd0, sw});
        if (sw) begin
            chk("R6", mem_addr_o, res);
            chk("R6", mem_wdata_o, b);
        end
        if (alu_used) begin
            chk("R11", {31'd0, alu_zero_o}, {31'd0, res == 32'd0});
            chk("R11", {31'd0, alu_ovf_o}, {31'd0, ovf});
        end
        if (we && wa != 5'd0) begin
            mrf[wa] = (ins[31:26] == 6'b100010) ? mdm[res[7:2]] : res;
        end
        if (sw) mdm[res[7:2]] = b;
        mpc = nxt;
    endtask

    task automatic load_word(logic sel, logic [31:0] addr, logic [31:0] data);
        @(negedge clk);
        load_en = 1'b1; load_sel = sel; load_addr = addr; load_data = data;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin prog[i] = '0; mdm[i] = '0; end
        for (int i = 0; i < 32; i++) mrf[i] = '0;
        prog[0]  = enc_i(6'b100010, 0, 1, 0);            // lw  r1 = 7fffffff
        prog[1]  = enc_i(6'b100010, 0, 2, 4);            // lw  r2 = 1
        prog[2]  = enc_r(1, 2, 3, 6'b100000);            // add overflow (R11)
        prog[3]  = enc_r(0, 2, 4, 6'b100010);            // sub -> -1
        prog[4]  = enc_r(1, 4, 5, 6'b100100);            // and
        prog[5]  = enc_r(2, 4, 6, 6'b100101);            // or
        prog[6]  = enc_r(0, 0, 7, 6'b100111);            // nor
        prog[7]  = enc_r(4, 2, 8, 6'b101010);            // slt -1<1 -> 1 (R4)
        prog[8]  = enc_r(2, 4, 9, 6'b101010);            // slt 1<-1 -> 0
        prog[9]  = enc_r(1, 2, 0, 6'b100000);            // write to r0 dropped (R9)
        prog[10] = enc_i(6'b101011, 0, 0, 12);           // store r0
        prog[11] = {6'b111111, 26'h155aa};               // unknown opcode (R10)
        prog[12] = enc_i(6'b000100, 1, 2, 2);            // beq not taken
        prog[13] = enc_i(6'b000100, 2, 2, 2);            // beq taken -> 16
        prog[14] = enc_r(1, 1, 10, 6'b100000);           // skipped
        prog[15] = enc_r(1, 1, 11, 6'b100000);           // skipped
        prog[16] = enc_i(6'b100010, 0, 11, 8);           // lw negative value
        prog[17] = enc_i(6'b101011, 7, 11, 21);          // sw at -1+21 = 20
        prog[18] = enc_i(6'b100010, 0, 12, 20);          // lw back
        prog[19] = enc_r(12, 11, 13, 6'b100010);         // sub -> zero
        prog[20] = enc_j(22);                            // jump
        prog[21] = enc_r(1, 1, 14, 6'b100000);           // skipped
        prog[22] = enc_i(6'b000100, 0, 0, -1);           // backward branch to self
        plen = 23;
        mdm[0] = 32'h7fffffff;
        mdm[1] = 32'h00000001;
        mdm[2] = 32'hfffffff0;
        mdm[3] = 32'h00000005;

        // R12: fill both arrays through the load port while in reset
        for (int i = 0; i < plen; i++) load_word(1'b0, 32'(i * 4), prog[i]);
        for (int i = 0; i < 4; i++) load_word(1'b1, 32'(i * 4), mdm[i]);

        // R1: reset state
        @(negedge clk); #0.5;
        chk("R1", pc_o, 32'd0);
        chk("R1", {31'd0, reg_we_o}, 32'd0);
        chk("R1", {31'd0, mem_we_o}, 32'd0);
        mpc = 32'd0;
        rst = 1'b0;
        #0.5;
        step();
        for (int c = 0; c < 40; c++) begin
            @(negedge clk); #0.5;
            step();
        end
        chk("R7", pc_o, 32'd88);

        // R1: reset mid-run returns the PC to zero, no writes while held
        @(negedge clk);
        rst = 1'b1;
        #0.5;
        chk("R1", {31'd0, reg_we_o}, 32'd0);
        chk("R1", {31'd0, mem_we_o}, 32'd0);
        @(negedge clk); #0.5;
        chk("R1", pc_o, 32'd0);
        mpc = 32'd0;
        rst = 1'b0;
        #0.5;
        step();
        for (int c = 0; c < 30; c++) begin
            @(negedge clk); #0.5;
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule